// File: doc/BRIEF.md
# Streaming Running Max/Min Line Filter

This block filters one line of grey-scale pixels at a time. For every pixel position it returns the largest value (dilation) or the smallest value (erosion) inside a flat window. The window reaches a programmable number of samples to the left and to the right of that position. Pixels enter one per handshake. Results leave in position order through a second handshake. There are no stored line buffers: a short queue holds only those candidate values that could still become a result.

Each queue slot holds a pixel value and a position stamp. The stamp is the read position modulo the window span. A two-phase controller runs each input sample through the queue in two steps. In the trim phase it discards the back entries that the new sample supersedes, several at once where possible, and then appends the sample. In the emit phase it presents the front value as a result and drops the front entry if it is about to leave the window. When the last pixel of a line has been taken, the remaining results are produced without further input. The queue is then emptied for the next line. The operation, both window reaches and the line length are taken from the configuration inputs when the first pixel of a line is accepted.

Top module: `run_extremum_filter`

## Requirements
- R1: With cfg_erode=0, the result for position p of a line of length N equals the maximum of the inputs at positions max(0,p-L) through min(N-1,p+R), where L=cfg_left and R=cfg_right.
- R2: With cfg_erode=1, the result is the minimum over the same clipped window, and runs of equal values are handled.
- R3: Each line yields exactly N results, in position order. After the last pixel of a line is accepted, exactly min(R+1,N) results are still delivered. The next line then starts from an empty queue.
- R4: cfg_erode, cfg_left, cfg_right and cfg_len are sampled only on the clock edge that accepts the first pixel of a line. Changing them later in the line has no effect on that line's results.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R6: in_ready and out_valid are never high in the same cycle.
- R7: Let span S=L+R+1 and let DL be the smallest integer of at least 1 whose square is at least S-1. While a sample waits, each cycle removes DL back entries if the entry DL places from the back is superseded. Otherwise it removes one entry if the back entry is superseded. Otherwise it accepts the sample. Consecutive accepts are therefore 2 cycles apart plus the removal cycles, and a run of removals never exceeds (S-1)/DL+DL-1 cycles. For example, with S=11 (DL=4), clearing ten entries takes 4 cycles, so the accepts are 6 cycles apart.
- R8: Lines shorter than the window, down to N=1, give correctly clipped results.
- R9: With L=R=0, every result equals its input pixel.
- R10: In the cycle after reset is asserted, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_erode | input | 1 | 0 selects running max, 1 selects running min |
| cfg_left | input | SIDE_W (4) | Window reach to the left |
| cfg_right | input | SIDE_W (4) | Window reach to the right |
| cfg_len | input | LINE_W (11) | Pixels in the line (at least 1) |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Input pixel taken at this edge |
| in_data | input | PIX_W (8) | Input pixel |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken at this edge |
| out_data | output | PIX_W (8) | Result pixel |

## Verification
In the emit phase two things happen in the same cycle: the front entry is removed because it is leaving the window, and the front value is presented as the current result. The result must be the value as it was before that removal. This collision is forced on purpose in three ways: a unit window, where every entry expires in the cycle it is emitted; a strictly falling run, where the oldest queued value is the current maximum exactly as it ages out; and output backpressure, which holds the emit cycle open across several edges. Every result is compared against a brute-force clipped window maximum or minimum computed from the stimulus. The spacing between accepts is also measured around a falling run that ends in a spike.

// File: rtl/runext_pkg.sv
package runext_pkg;

    localparam int PIX_W    = 8;
    localparam int SIDE_MAX = 15;
    localparam int LINE_W   = 11;

    localparam int SIDE_W   = $clog2(SIDE_MAX + 1);
    localparam int SPAN_MAX = 2 * SIDE_MAX + 1;
    localparam int SPAN_W   = $clog2(SPAN_MAX + 1);
    localparam int STAMP_W  = $clog2(SPAN_MAX);
    localparam int Q_PW     = $clog2(SPAN_MAX);
    localparam int Q_DEPTH  = 1 << Q_PW;
    localparam int CNT_W    = $clog2(SPAN_MAX + 1);
    localparam int POS_W    = LINE_W + 1;

    typedef enum logic {ST_TRIM = 1'b0, ST_EMIT = 1'b1} phase_e;
    typedef enum logic {OP_MAX = 1'b0, OP_MIN = 1'b1} op_e;

    typedef struct packed {
        logic [PIX_W-1:0]   val;
        logic [STAMP_W-1:0] stamp;
    } slot_t;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } rel_t;

    function automatic rel_t relate(input logic [PIX_W-1:0] a,
                                    input logic [PIX_W-1:0] b);
        rel_t r;
        r.gt = (a > b);
        r.lt = (a < b);
        r.eq = (a == b);
        return r;
    endfunction

    // Smallest k >= 1 with k*k >= span-1: bulk removal step for a span.
    function automatic int unsigned dl_for_span(input int unsigned span);
        int unsigned need;
        int unsigned r;
        need = (span > 1) ? span - 1 : 0;
        r = 1;
        for (int k = SPAN_MAX; k >= 1; k--) begin
            if (k * k >= need) r = k;
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_queue.sv
module rx_queue
    import runext_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  slot_t            push_slot,
    input  logic             pop_front,
    input  logic [CNT_W-1:0] drop_n,
    input  logic [CNT_W-1:0] ref_dist,
    output logic [CNT_W-1:0] count,
    output slot_t            front_slot,
    output logic [PIX_W-1:0] back_val,
    output logic [PIX_W-1:0] ref_val
);

    slot_t            mem [Q_DEPTH];
    logic [Q_PW-1:0]  head_q;
    logic [Q_PW-1:0]  tail_q;
    logic [CNT_W-1:0] count_q;
    slot_t            back_slot;
    slot_t            ref_slot;

    always_ff @(posedge clk) begin
        if (push) mem[tail_q] <= push_slot;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= head_q + Q_PW'(pop_front);
            tail_q  <= tail_q + Q_PW'(push) - Q_PW'(drop_n);
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop_front) - drop_n;
        end
    end

    always_comb begin
        front_slot = mem[head_q];
        back_slot  = mem[tail_q - Q_PW'(1)];
        ref_slot   = mem[tail_q - Q_PW'(ref_dist)];
        back_val   = back_slot.val;
        ref_val    = ref_slot.val;
        count      = count_q;
    end

endmodule

// File: rtl/rx_compare.sv
module rx_compare
    import runext_pkg::*;
(
    input  op_e              op,
    input  logic [PIX_W-1:0] sample,
    input  logic [PIX_W-1:0] back_val,
    input  logic [PIX_W-1:0] ref_val,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] dl,
    output logic [CNT_W-1:0] drop_n
);

    rel_t rb;
    rel_t rr;
    logic kill_back;
    logic kill_ref;

    always_comb begin
        rb = relate(back_val, sample);
        rr = relate(ref_val, sample);
        kill_back = (op == OP_MAX) ? (rb.lt | rb.eq) : (rb.gt | rb.eq);
        kill_ref  = (op == OP_MAX) ? (rr.lt | rr.eq) : (rr.gt | rr.eq);
        if (count >= dl && kill_ref)
            drop_n = dl;
        else if (count != '0 && kill_back)
            drop_n = CNT_W'(1);
        else
            drop_n = '0;
    end

endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
    import runext_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  op_e                cfg_op,
    input  logic [SIDE_W-1:0]  cfg_left,
    input  logic [SIDE_W-1:0]  cfg_right,
    input  logic [LINE_W-1:0]  cfg_len,
    input  logic               in_valid,
    input  logic               out_ready,
    input  logic [CNT_W-1:0]   cmp_drop,
    input  logic [CNT_W-1:0]   q_count,
    input  logic [STAMP_W-1:0] front_stamp,
    output logic               in_ready,
    output logic               out_valid,
    output logic               q_push,
    output logic               q_pop,
    output logic               q_clear,
    output logic [CNT_W-1:0]   q_drop,
    output logic [STAMP_W-1:0] push_stamp,
    output op_e                op_now,
    output logic [CNT_W-1:0]   dl_now,
    output logic [SPAN_W-1:0]  span_now
);

    phase_e              st_q;
    logic [POS_W-1:0]    vp_q;
    logic [STAMP_W-1:0]  stamp_q;
    op_e                 op_q;
    logic [SIDE_W-1:0]   right_q;
    logic [SPAN_W-1:0]   span_q;
    logic [LINE_W-1:0]   len_q;
    logic [CNT_W-1:0]    dl_q;

    logic [CNT_W-1:0]    dl_lut [SPAN_MAX+1];
    logic [SPAN_W-1:0]   cfg_span;
    logic                line_start;
    logic                trim_go;
    logic                accept;
    logic                emit_due;
    logic                step;
    logic                at_end;
    logic [STAMP_W-1:0]  stamp_nxt;
    logic [POS_W-1:0]    last_pos;

    for (genvar g = 0; g <= SPAN_MAX; g++) begin : g_dl
        assign dl_lut[g] = CNT_W'(dl_for_span(g));
    end

    always_comb begin
        cfg_span   = SPAN_W'(cfg_left) + SPAN_W'(cfg_right) + SPAN_W'(1);
        line_start = (vp_q == '0);
        op_now     = line_start ? cfg_op : op_q;
        dl_now     = dl_q;
        span_now   = span_q;

        trim_go  = (st_q == ST_TRIM) && in_valid;
        q_drop   = (trim_go && !line_start) ? cmp_drop : '0;
        accept   = trim_go && (q_drop == '0);
        in_ready = accept;
        q_push   = accept;
        push_stamp = stamp_q;

        emit_due  = (st_q == ST_EMIT) && (vp_q >= POS_W'(right_q));
        out_valid = emit_due;
        step      = (st_q == ST_EMIT) && (!emit_due || out_ready);

        stamp_nxt = (stamp_q == STAMP_W'(span_q - SPAN_W'(1))) ? '0 : stamp_q + STAMP_W'(1);
        last_pos  = POS_W'(len_q) - POS_W'(1) + POS_W'(right_q);
        at_end    = (vp_q == last_pos);

        q_pop   = step && !at_end && (q_count != '0) && (front_stamp == stamp_nxt);
        q_clear = step && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_TRIM;
            vp_q    <= '0;
            stamp_q <= '0;
            op_q    <= OP_MAX;
            right_q <= '0;
            span_q  <= SPAN_W'(1);
            len_q   <= LINE_W'(1);
            dl_q    <= CNT_W'(1);
        end else begin
            if (accept && line_start) begin
                op_q    <= cfg_op;
                right_q <= cfg_right;
                span_q  <= cfg_span;
                len_q   <= cfg_len;
                dl_q    <= dl_lut[cfg_span];
            end
            if (accept) st_q <= ST_EMIT;
            if (step) begin
                if (at_end) begin
                    vp_q    <= '0;
                    stamp_q <= '0;
                    st_q    <= ST_TRIM;
                end else begin
                    vp_q    <= vp_q + POS_W'(1);
                    stamp_q <= stamp_nxt;
                    st_q    <= (vp_q + POS_W'(1) < POS_W'(len_q)) ? ST_TRIM : ST_EMIT;
                end
            end
        end
    end

endmodule

// File: rtl/run_extremum_filter.sv
module run_extremum_filter
    import runext_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_erode,
    input  logic [SIDE_W-1:0] cfg_left,
    input  logic [SIDE_W-1:0] cfg_right,
    input  logic [LINE_W-1:0] cfg_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_data
);

    slot_t               front_slot;
    slot_t               push_slot;
    logic [PIX_W-1:0]    back_val;
    logic [PIX_W-1:0]    ref_val;
    logic [CNT_W-1:0]    q_count;
    logic [CNT_W-1:0]    q_drop;
    logic [CNT_W-1:0]    cmp_drop;
    logic [CNT_W-1:0]    dl_now;
    logic [SPAN_W-1:0]   span_now;
    logic [STAMP_W-1:0]  push_stamp;
    logic                q_push;
    logic                q_pop;
    logic                q_clear;
    op_e                 op_now;
    op_e                 cfg_op;

    assign cfg_op    = op_e'(cfg_erode);
    assign push_slot = '{val: in_data, stamp: push_stamp};
    assign out_data  = front_slot.val;

    rx_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cfg_op     (cfg_op),
        .cfg_left   (cfg_left),
        .cfg_right  (cfg_right),
        .cfg_len    (cfg_len),
        .in_valid   (in_valid),
        .out_ready  (out_ready),
        .cmp_drop   (cmp_drop),
        .q_count    (q_count),
        .front_stamp(front_slot.stamp),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .q_push     (q_push),
        .q_pop      (q_pop),
        .q_clear    (q_clear),
        .q_drop     (q_drop),
        .push_stamp (push_stamp),
        .op_now     (op_now),
        .dl_now     (dl_now),
        .span_now   (span_now)
    );

    rx_compare u_cmp (
        .op      (op_now),
        .sample  (in_data),
        .back_val(back_val),
        .ref_val (ref_val),
        .count   (q_count),
        .dl      (dl_now),
        .drop_n  (cmp_drop)
    );

    rx_queue u_queue (
        .clk       (clk),
        .rst       (rst),
        .clear     (q_clear),
        .push      (q_push),
        .push_slot (push_slot),
        .pop_front (q_pop),
        .drop_n    (q_drop),
        .ref_dist  (dl_now),
        .count     (q_count),
        .front_slot(front_slot),
        .back_val  (back_val),
        .ref_val   (ref_val)
    );

endmodule

// File: rtl/rx_checker.sv
module rx_checker
    import runext_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [PIX_W-1:0]  out_data,
    input logic [CNT_W-1:0]  q_drop,
    input logic [CNT_W-1:0]  dl_now,
    input logic [SPAN_W-1:0] span_now
);

    int run_q;
    int bound_w;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 0;
        else     run_q <= (q_drop != '0) ? run_q + 1 : 0;
    end

    always_comb begin
        bound_w = (int'(span_now) - 1) / int'(dl_now) + int'(dl_now) - 1;
    end

    // R5
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6
    exclusive_hs_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    // R7
    drop_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (q_drop != '0) |-> (run_q < bound_w));

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind run_extremum_filter rx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .q_drop   (q_drop),
    .dl_now   (dl_now),
    .span_now (span_now)
);

// File: tb/sim_run_extremum_filter.sv
module sim_run_extremum_filter;
    import runext_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAXN = 256;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_erode = 1'b0;
    logic [SIDE_W-1:0] cfg_left = '0;
    logic [SIDE_W-1:0] cfg_right = '0;
    logic [LINE_W-1:0] cfg_len = LINE_W'(1);
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [PIX_W-1:0]  in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [PIX_W-1:0]  out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_got = 0;
    int bp_mode = 0;
    int gap_mode = 0;
    bit scramble = 1'b0;
    int excl_viol = 0;
    int hold_viol = 0;
    bit prev_stall = 1'b0;
    logic [PIX_W-1:0] prev_data = '0;

    logic [PIX_W-1:0] pix [MAXN];
    logic [PIX_W-1:0] got [MAXN];
    int got_cyc [MAXN];
    int acc_cyc [MAXN];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    run_extremum_filter u0 (
        .clk(clk), .rst(rst), .cfg_erode(cfg_erode), .cfg_left(cfg_left),
        .cfg_right(cfg_right), .cfg_len(cfg_len), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // handshake monitor for R5 and R6
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            if (in_ready && out_valid) excl_viol++;
            if (prev_stall && !(out_valid && out_data == prev_data)) hold_viol++;
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end else begin
            prev_stall = 1'b0;
        end
    end

    function automatic int window_ref(input int wp, input int n, input int l,
                                      input int r, input bit ero);
        int lo;
        int hi;
        int v;
        lo = (wp - l < 0) ? 0 : wp - l;
        hi = (wp + r > n - 1) ? n - 1 : wp + r;
        v = int'(pix[lo]);
        for (int k = lo; k <= hi; k++) begin
            if (ero) v = (int'(pix[k]) < v) ? int'(pix[k]) : v;
            else     v = (int'(pix[k]) > v) ? int'(pix[k]) : v;
        end
        return v;
    endfunction

    task automatic drive_line(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (scramble && i == 1) begin
                cfg_erode = ~cfg_erode;
                cfg_left  = SIDE_W'(7);
                cfg_right = SIDE_W'(9);
                cfg_len   = LINE_W'(5);
            end
            if (gap_mode != 0 && i % 4 == 2) begin
                in_valid = 1'b0;
                repeat (3) @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = pix[i];
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            acc_cyc[i] = cyc;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic collect_line(input int n);
        n_got = 0;
        while (n_got < n) begin
            @(negedge clk);
            out_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            #1;
            if (out_valid && out_ready) begin
                got[n_got]     = out_data;
                got_cyc[n_got] = cyc;
                n_got++;
            end
        end
    endtask

    task automatic run_line(input string req, input bit ero, input int l,
                            input int r, input int n);
        @(negedge clk);
        cfg_erode = ero;
        cfg_left  = SIDE_W'(l);
        cfg_right = SIDE_W'(r);
        cfg_len   = LINE_W'(n);
        fork
            drive_line(n);
            collect_line(n);
        join
        for (int i = 0; i < n; i++) begin
            check(int'(got[i]) == window_ref(i, n, l, r, ero), req,
                  int'(got[i]), window_ref(i, n, l, r, ero));
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R10 out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b0, "R10 in_ready idle", int'(in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_dilate();
        for (int i = 0; i < 40; i++) pix[i] = PIX_W'((i * 73 + 29) % 251);
        bp_mode = 1;
        run_line("R1 dilation", 1'b0, 3, 2, 40);
        bp_mode = 0;
    endtask

    task automatic t_erode();
        for (int i = 0; i < 33; i++) pix[i] = PIX_W'(((i / 3) * 53) % 200);
        gap_mode = 1;
        run_line("R2 erosion plateaus", 1'b1, 0, 4, 33);
        gap_mode = 0;
    endtask

    task automatic t_tail();
        int after;
        for (int i = 0; i < 20; i++) pix[i] = PIX_W'((i * 29 + 7) % 97);
        run_line("R3 order", 1'b0, 2, 6, 20);
        check(n_got == 20, "R3 result count", n_got, 20);
        after = 0;
        for (int i = 0; i < 20; i++) if (got_cyc[i] > acc_cyc[19]) after++;
        check(after == 7, "R3 tail results", after, 7);
        for (int i = 0; i < 9; i++) pix[i] = PIX_W'(200 - i * 11);
        bp_mode = 1;
        run_line("R3 next line clean", 1'b1, 4, 1, 9);
        bp_mode = 0;
    endtask

    task automatic t_cfg_hold();
        for (int i = 0; i < 24; i++) pix[i] = PIX_W'((i * 41 + 3) % 173);
        scramble = 1'b1;
        run_line("R4 config held", 1'b0, 1, 1, 24);
        scramble = 1'b0;
    endtask

    task automatic t_burst();
        for (int i = 0; i < 11; i++) pix[i] = PIX_W'(110 - i);
        pix[11] = PIX_W'(200);
        for (int i = 12; i < 16; i++) pix[i] = PIX_W'(i * 5);
        run_line("R7 burst results", 1'b0, 5, 5, 16);
        check(acc_cyc[10] - acc_cyc[9] == 2, "R7 falling spacing",
              acc_cyc[10] - acc_cyc[9], 2);
        check(acc_cyc[11] - acc_cyc[10] == 6, "R7 bulk removal spacing",
              acc_cyc[11] - acc_cyc[10], 6);
    endtask

    task automatic t_short();
        pix[0] = PIX_W'(40); pix[1] = PIX_W'(12); pix[2] = PIX_W'(90);
        run_line("R8 short line", 1'b1, 2, 6, 3);
        pix[0] = PIX_W'(77);
        run_line("R8 single pixel", 1'b0, 0, 15, 1);
        for (int i = 0; i < 5; i++) pix[i] = PIX_W'(i * 17 + 1);
        run_line("R8 wide window", 1'b0, 15, 15, 5);
    endtask

    task automatic t_unit();
        for (int i = 0; i < 12; i++) pix[i] = PIX_W'((i * 97 + 5) % 256);
        bp_mode = 1;
        run_line("R9 unit window", 1'b1, 0, 0, 12);
        bp_mode = 0;
        for (int i = 0; i < 12; i++)
            check(got[i] == pix[i], "R9 passthrough", int'(got[i]), int'(pix[i]));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_dilate();
        t_erode();
        t_tail();
        t_cfg_hold();
        t_burst();
        t_short();
        t_unit();
        repeat (4) @(negedge clk);
        check(excl_viol == 0, "R6 in_ready with out_valid", excl_viol, 0);
        check(hold_viol == 0, "R5 stalled result changed", hold_viol, 0);
        finish_run();
    end

endmodule